// File: doc/BRIEF.md
# Non-maskable interrupt request unit

This unit turns an asynchronous non-maskable interrupt pin into a clean pending request for an instruction-sequencing core. The pin first passes through a chain of synchronizer flops. A low-to-high transition seen at the end of that chain sets a pending flag. The flag stays set until the core acknowledges it at an instruction boundary.

When the core accepts the request, the unit does two things. It tells the core to clear its interrupt-enable flag, and it presents the fixed vector number of the non-maskable entry. No mask gates the request. The unit keeps no in-service state, so a fresh rising edge that arrives while the previous request is being serviced raises a new request.

A parameter selects how the acceptance outputs are timed. In the default, they are combinational with the acknowledge. In the other variant, they are registered one cycle later. All synchronizer flops and the edge detector's history flop reset to high. As a result, a pin that is already high when reset ends is never taken for an edge.

Top module: `nmi_req_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_pend`, `clr_ie` and `vec_valid` are 0.
- R2: A rising edge of `nmi_pin` sampled at a clock edge makes `irq_pend` read 1 after exactly SYNC_STAGES+1 rising clock edges, counting the sampling edge, and not earlier. With the default of 2 stages, this is 3 edges.
- R3: Holding `nmi_pin` high after a request has been acknowledged creates no further request.
- R4: A pin held high through reset and after its release produces no request. A later low-then-high transition does produce one.
- R5: Once set, `irq_pend` stays 1 for any number of cycles while `take_ack` is 0.
- R6: `take_ack` high for one cycle while `irq_pend` is 1 clears `irq_pend` at the next clock edge, provided no new edge arrives in that cycle.
- R7: If a new edge reaches the pending flag in the same cycle as the acknowledge, `irq_pend` stays 1.
- R8: In the combinational variant (default), `clr_ie` and `vec_valid` are 1 in exactly the cycles where `take_ack` and `irq_pend` are both 1. `vec_num` always equals the VECTOR parameter, which defaults to 2.
- R9: `take_ack` while no request is pending leaves `clr_ie` and `vec_valid` at 0 and `irq_pend` at 0.
- R10: A new rising edge after an accepted request, while that request is being serviced, raises a fresh request. No in-service state blocks it.
- R11: A pin pulse that is high across one clock edge only is recognized.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| take_ack | input | 1 | Core accepts the request at an instruction boundary |
| irq_pend | output | 1 | Request pending toward the core |
| clr_ie | output | 1 | Core must clear its interrupt-enable flag |
| vec_valid | output | 1 | `vec_num` is being delivered for this acceptance |
| vec_num | output | VEC_W | Fixed vector number of the non-maskable entry |

## Verification
The pending flag is due SYNC_STAGES+1 clock edges after the edge that first samples the pin high. With two stages, the bench checks that it is still low after the first and second edges and high after the third. The acceptance outputs are combinational with `take_ack`, so the bench checks them one nanosecond after driving the acknowledge, before the next clock edge. The effect of the acknowledge on `irq_pend` is checked after the following edge. For the race case, the acknowledge is raised exactly two edges after the pin, which is the cycle in which the synchronized edge is present.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
   typedef enum logic {
      TAKE_COMB = 1'b0,
      TAKE_REG  = 1'b1
   } take_mode_e;

   localparam int MIN_SYNC = 2;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < nmi_pkg::MIN_SYNC) begin : g_bad_stages
      $error("nmi_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= 1'b1;
      else        hist_q <= lvl;
   end

   assign rise = lvl & ~hist_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3
endmodule

// File: rtl/nmi_pend.sv
module nmi_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic ack,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= set_req | (pend_q & ~ack);
   end

   assign pend = pend_q;

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack) |=> pend_q); // R5
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ack && !set_req) |=> !pend_q); // R6
   AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> pend_q); // R7
endmodule

// File: rtl/nmi_req_unit.sv
module nmi_req_unit #(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  VEC_W       = 8,
   parameter int                  VECTOR      = 2,
   parameter nmi_pkg::take_mode_e TAKE_MODE   = nmi_pkg::TAKE_COMB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_pin,
   input  logic             take_ack,
   output logic             irq_pend,
   output logic             clr_ie,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_num
);
   localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(VECTOR);

   if (VECTOR < 0 || VECTOR >= (1 << VEC_W)) begin : g_bad_vec
      $error("nmi_req_unit: VECTOR does not fit VEC_W");
   end

   logic pin_s;
   logic edge_rise;
   logic take;

   nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(nmi_pin), .dout(pin_s)
   );

   nmi_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .rise(edge_rise)
   );

   nmi_pend u_pend (
      .clk(clk), .rst_n(rst_n), .set_req(edge_rise), .ack(take_ack),
      .pend(irq_pend)
   );

   assign take    = take_ack & irq_pend;
   assign vec_num = VEC_CODE;

   if (TAKE_MODE == nmi_pkg::TAKE_REG) begin : g_take_reg
      logic take_q;
      always_ff @(posedge clk) begin
         if (!rst_n) take_q <= 1'b0;
         else        take_q <= take;
      end
      assign clr_ie    = take_q;
      assign vec_valid = take_q;
   end else begin : g_take_comb
      assign clr_ie    = take;
      assign vec_valid = take;
   end

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> $past(edge_rise)); // R2
   AST_CLR_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ie |-> (vec_valid && vec_num == VEC_CODE)); // R8
endmodule

// File: tb/sim_nmi_req_unit.sv
module sim_nmi_req_unit;
   localparam int S   = 2;
   localparam int VW  = 8;
   localparam int VEC = 2;
   localparam int LAT = S + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi_pin = 1'b0;
   logic take_ack = 1'b0;
   logic irq_pend, clr_ie, vec_valid;
   logic [VW-1:0] vec_num;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nmi_req_unit #(.SYNC_STAGES(S), .VEC_W(VW), .VECTOR(VEC)) u0 (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .take_ack(take_ack),
      .irq_pend(irq_pend), .clr_ie(clr_ie), .vec_valid(vec_valid),
      .vec_num(vec_num)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ack_once();
      take_ack = 1'b1;
      tick(1);
      take_ack = 1'b0;
   endtask

   task automatic make_edge();
      nmi_pin = 1'b0;
      tick(4);
      nmi_pin = 1'b1;
      tick(LAT);
   endtask

   initial begin
      tick(3);
      chk("R1 pend in reset", int'(irq_pend), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 pend after reset", int'(irq_pend), 0);
      chk("R1 clr_ie after reset", int'(clr_ie), 0);
      chk("R1 vec_valid after reset", int'(vec_valid), 0);

      take_ack = 1'b1;
      #1;
      chk("R9 clr_ie without pend", int'(clr_ie), 0);
      chk("R9 vec_valid without pend", int'(vec_valid), 0);
      tick(1);
      take_ack = 1'b0;
      chk("R9 pend stays low", int'(irq_pend), 0);

      nmi_pin = 1'b1;
      tick(1);
      nmi_pin = 1'b0;
      chk("R2 pend after 1 edge", int'(irq_pend), 0);
      tick(1);
      chk("R2 pend after 2 edges", int'(irq_pend), 0);
      tick(1);
      chk("R11 short pulse seen after 3 edges", int'(irq_pend), 1);

      tick(10);
      chk("R5 pend held", int'(irq_pend), 1);

      take_ack = 1'b1;
      #1;
      chk("R8 clr_ie on take", int'(clr_ie), 1);
      chk("R8 vec_valid on take", int'(vec_valid), 1);
      chk("R8 vec_num", int'(vec_num), VEC);
      tick(1);
      take_ack = 1'b0;
      #1;
      chk("R6 pend cleared", int'(irq_pend), 0);
      chk("R8 clr_ie drops", int'(clr_ie), 0);

      make_edge();
      chk("R2 level edge pending", int'(irq_pend), 1);
      ack_once();
      tick(10);
      chk("R3 held level no new request", int'(irq_pend), 0);

      make_edge();
      chk("R10 fresh request during service", int'(irq_pend), 1);
      ack_once();
      chk("R10 cleared", int'(irq_pend), 0);

      make_edge();
      chk("R7 setup pend", int'(irq_pend), 1);
      nmi_pin = 1'b0;
      tick(4);
      nmi_pin = 1'b1;
      tick(S);
      take_ack = 1'b1;
      #1;
      chk("R8 clr_ie in race", int'(clr_ie), 1);
      tick(1);
      take_ack = 1'b0;
      chk("R7 pend kept on race", int'(irq_pend), 1);
      ack_once();
      chk("R7 later ack clears", int'(irq_pend), 0);

      nmi_pin = 1'b1;
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(10);
      chk("R4 high through reset ignored", int'(irq_pend), 0);
      make_edge();
      chk("R4 later edge recognized", int'(irq_pend), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule